// File: doc/BRIEF.md
# Sixteen-bit timer with match-driven output pins

This block is a 16-bit up-counter that advances on a clock-enable tick. It has two counting behaviours, chosen by a 4-bit mode input. In free-running operation it wraps from the all-ones value back to zero. In clear-on-match operation it returns to zero on the tick after it reaches a top value. That top value comes from compare register A or from a capture register, depending on the mode code.

Two compare channels, A and B, watch the count. Each channel owns an output pin and a 2-bit action field. On a compare match the channel sets, clears or toggles its pin, or leaves it alone. A per-channel force strobe applies the same action straight away, without a real match.

Sticky flags report a counter wrap and each channel's matches. Each flag stays set until its clear input is pulsed. All registers have their own write ports.

Top module: `match_timer`

## Requirements
- R1: Mode code 0 counts up by one on each tick, wraps from 0xFFFF to 0x0000, and is never cleared by a match. Any code other than 4 or 12 counts the same way.
- R2: The overflow flag sets on the tick on which the count wraps from 0xFFFF to zero. A return to zero caused by a top-value clear does not set it.
- R3: The overflow flag is cleared only by the overflow clear input. If a wrap and the clear arrive on the same cycle, the flag ends up set.
- R4: Under mode code 4, a tick taken while the count equals compare register A makes the count zero.
- R5: Under mode code 12, a tick taken while the count equals the capture register makes the count zero. Compare register A then has no effect on the count.
- R6: Without a tick or a counter write, the count holds its value.
- R7: A counter write loads the written value on that edge, with priority over counting and clearing. A compare match on that cycle is blocked: it sets no flag and moves no pin.
- R8: A channel's match flag sets on a tick taken while the count equals that channel's compare register. The flag holds until that channel's flag clear input is pulsed.
- R9: On a match, a channel's 2-bit action field acts on its pin: 00 leaves it, 01 toggles it, 10 drives it low, 11 drives it high.
- R10: Writing an action field does not change the pin. The new value first acts at the next match or force.
- R11: A force strobe applies the channel's current action to its pin on the next edge. It sets no match flag and does not change the count.
- R12: After reset the count, all registers, all flags and both pins are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable |
| mode | input | 4 | Counting mode code |
| cnt_we | input | 1 | Counter write enable |
| cnt_wdata | input | 16 | Counter write value |
| cmpa_we | input | 1 | Compare A write enable |
| cmpb_we | input | 1 | Compare B write enable |
| cap_we | input | 1 | Capture register write enable |
| reg_wdata | input | 16 | Shared write value for compare and capture registers |
| acta_we | input | 1 | Channel A action write enable |
| actb_we | input | 1 | Channel B action write enable |
| act_wdata | input | 2 | Action field write value |
| force_a | input | 1 | Channel A force strobe |
| force_b | input | 1 | Channel B force strobe |
| ovf_clr | input | 1 | Overflow flag clear |
| flga_clr | input | 1 | Channel A match flag clear |
| flgb_clr | input | 1 | Channel B match flag clear |
| count | output | 16 | Current count |
| ovf | output | 1 | Overflow flag |
| flag_a | output | 1 | Channel A match flag |
| flag_b | output | 1 | Channel B match flag |
| pin_a | output | 1 | Channel A output pin |
| pin_b | output | 1 | Channel B output pin |

## Verification
The bench walks the count across the 0xFFFF wrap and across each top value. A design that raised the overflow flag on a top-value clear, or cleared from the wrong register under mode 12, shows a wrong flag or count there. It lines up a wrap with a flag clear, and a match with a counter write. Getting the priority wrong in either case loses the flag or moves a pin when nothing should have happened. It rewrites an action field between matches and pulses the force strobes with the counter stopped. A design that applied the new action at once, or let a force set a flag or disturb the count, is caught on the next sample.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int CNT_W  = 16,
  parameter int MODE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [MODE_W-1:0] mode,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmpa_we,
  input  logic             cmpb_we,
  input  logic             cap_we,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             acta_we,
  input  logic             actb_we,
  input  logic [1:0]       act_wdata,
  input  logic             force_a,
  input  logic             force_b,
  input  logic             ovf_clr,
  input  logic             flga_clr,
  input  logic             flgb_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             flag_a,
  output logic             flag_b,
  output logic             pin_a,
  output logic             pin_b
);

  localparam logic [CNT_W-1:0]  MAXV     = '1;
  localparam logic [MODE_W-1:0] MODE_TOA = MODE_W'(4);
  localparam logic [MODE_W-1:0] MODE_TOC = MODE_W'(12);

  logic [CNT_W-1:0] cmpa_q, cmpb_q, cap_q;
  logic [1:0]       acta_q, actb_q;

  wire adv      = tick && !cnt_we;
  wire hit_a    = adv && (count == cmpa_q);
  wire hit_b    = adv && (count == cmpb_q);
  wire at_top   = ((mode == MODE_TOA) && (count == cmpa_q)) ||
                  ((mode == MODE_TOC) && (count == cap_q));
  wire wrap     = adv && !at_top && (count == MAXV);

  function automatic logic act(input logic [1:0] a, input logic p);
    case (a)
      2'b01:   act = !p;
      2'b10:   act = 1'b0;
      2'b11:   act = 1'b1;
      default: act = p;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      cap_q  <= '0;
      acta_q <= '0;
      actb_q <= '0;
      ovf    <= 1'b0;
      flag_a <= 1'b0;
      flag_b <= 1'b0;
      pin_a  <= 1'b0;
      pin_b  <= 1'b0;
    end else begin
      if (cnt_we)      count <= cnt_wdata;
      else if (adv)    count <= at_top ? '0 : count + 1'b1;
      if (cmpa_we)     cmpa_q <= reg_wdata;
      if (cmpb_we)     cmpb_q <= reg_wdata;
      if (cap_we)      cap_q  <= reg_wdata;
      if (acta_we)     acta_q <= act_wdata;
      if (actb_we)     actb_q <= act_wdata;
      if (wrap)          ovf <= 1'b1;
      else if (ovf_clr)  ovf <= 1'b0;
      if (hit_a)         flag_a <= 1'b1;
      else if (flga_clr) flag_a <= 1'b0;
      if (hit_b)         flag_b <= 1'b1;
      else if (flgb_clr) flag_b <= 1'b0;
      if (hit_a || force_a) pin_a <= act(acta_q, pin_a);
      if (hit_b || force_b) pin_b <= act(actb_q, pin_b);
    end
  end

  assert_count_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == '0 && tick && !cnt_we && count != MAXV) |=> count == $past(count) + 1'b1);
  assert_wrap_ovf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == '0 && tick && !cnt_we && count == MAXV) |=> (count == '0 && ovf));
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  assert_top_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TOA && tick && !cnt_we && count == cmpa_q) |=> count == '0);
  assert_top_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TOC && tick && !cnt_we && count == cap_q) |=> count == '0);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(count));
  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> count == $past(cnt_wdata));
  assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && count == cmpa_q && acta_q == 2'b01) |=> pin_a != $past(pin_a));
  assert_idle_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acta_q == 2'b00) |=> $stable(pin_a));
  assert_force_noflag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (force_a && !tick && !flag_a) |=> !flag_a);

endmodule

// File: tb/test_match_timer.sv
module test_match_timer;
  logic clk = 0, rst_n = 0;
  logic tick = 0, cnt_we = 0, cmpa_we = 0, cmpb_we = 0, cap_we = 0;
  logic acta_we = 0, actb_we = 0, force_a = 0, force_b = 0;
  logic ovf_clr = 0, flga_clr = 0, flgb_clr = 0;
  logic [3:0] mode = 0;
  logic [15:0] cnt_wdata = 0, reg_wdata = 0;
  logic [1:0] act_wdata = 0;
  logic [15:0] count;
  logic ovf, flag_a, flag_b, pin_a, pin_b;
  int n_run = 0, n_fail = 0, cycles = 0;

  match_timer i_match_timer (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d exp=<100000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    tick = 0; cnt_we = 0; cmpa_we = 0; cmpb_we = 0; cap_we = 0;
    acta_we = 0; actb_we = 0; force_a = 0; force_b = 0;
    ovf_clr = 0; flga_clr = 0; flgb_clr = 0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    cnt_we = 1; cnt_wdata = v; cyc();
  endtask
  task automatic one_tick(); tick = 1; cyc(); endtask
  task automatic wr_reg(input int which, input logic [15:0] v);
    reg_wdata = v;
    if (which == 0) cmpa_we = 1; else if (which == 1) cmpb_we = 1; else cap_we = 1;
    cyc();
  endtask
  task automatic wr_act(input int ch, input logic [1:0] v);
    act_wdata = v;
    if (ch == 0) acta_we = 1; else actb_we = 1;
    cyc();
  endtask

  task automatic t_reset();
    chk("R12 count", count, 0); chk("R12 ovf", ovf, 0);
    chk("R12 flag_a", flag_a, 0); chk("R12 flag_b", flag_b, 0);
    chk("R12 pins", {pin_a, pin_b}, 0);
    wr_reg(0, 16'h8000); wr_reg(1, 16'h9000);
  endtask

  task automatic t_normal();
    mode = 0;
    wr_cnt(16'hFFFD);
    one_tick(); chk("R1 up", count, 16'hFFFE); chk("R2 no ovf", ovf, 0);
    one_tick(); chk("R1 max", count, 16'hFFFF);
    one_tick(); chk("R1 wrap", count, 0); chk("R2 ovf set", ovf, 1);
    one_tick(); chk("R1 after wrap", count, 1);
    mode = 3; wr_cnt(5); one_tick(); chk("R1 other code", count, 6);
    mode = 0;
  endtask

  task automatic t_ovf();
    one_tick(); one_tick(); chk("R3 sticky", ovf, 1);
    ovf_clr = 1; cyc(); chk("R3 cleared", ovf, 0);
    wr_cnt(16'hFFFF); tick = 1; ovf_clr = 1; cyc();
    chk("R3 set wins", ovf, 1);
    ovf_clr = 1; cyc(); chk("R3 clear again", ovf, 0);
  endtask

  task automatic t_ctc_a();
    mode = 4; wr_reg(0, 10); flga_clr = 1; cyc();
    wr_cnt(9);
    one_tick(); chk("R4 reach top", count, 10); chk("R8 no flag yet", flag_a, 0);
    one_tick(); chk("R4 clear", count, 0); chk("R2 no ovf on clear", ovf, 0);
    chk("R8 flag a", flag_a, 1);
    one_tick(); chk("R4 restart", count, 1);
  endtask

  task automatic t_ctc_cap();
    mode = 12; wr_reg(2, 20);
    wr_cnt(10); one_tick(); chk("R5 passes cmp A", count, 11);
    wr_cnt(20); one_tick(); chk("R5 clear at cap", count, 0);
    chk("R5 no ovf", ovf, 0);
  endtask

  task automatic t_hold();
    mode = 0; wr_cnt(16'h1234);
    cyc(); cyc(); cyc(); chk("R6 hold", count, 16'h1234);
  endtask

  task automatic t_write();
    mode = 4; wr_reg(0, 50); flga_clr = 1; cyc();
    wr_cnt(50); chk("R7 no flag on write", flag_a, 0);
    tick = 1; cnt_we = 1; cnt_wdata = 7; cyc();
    chk("R7 write beats clear", count, 7); chk("R7 match blocked", flag_a, 0);
    mode = 0;
  endtask

  task automatic t_flags();
    wr_reg(1, 30); flgb_clr = 1; cyc();
    wr_cnt(29); one_tick(); chk("R8 b not yet", flag_b, 0);
    one_tick(); chk("R8 b set", flag_b, 1); chk("R8 a untouched", flag_a, 0);
    one_tick(); chk("R8 b held", flag_b, 1);
    flgb_clr = 1; cyc(); chk("R8 b cleared", flag_b, 0);
  endtask

  task automatic t_pins();
    wr_reg(0, 40); chk("R9 pin start", pin_a, 0);
    wr_act(0, 2'b01);
    wr_cnt(40); one_tick(); chk("R9 toggle up", pin_a, 1);
    wr_cnt(40); one_tick(); chk("R9 toggle down", pin_a, 0);
    wr_act(0, 2'b11); wr_cnt(40); one_tick(); chk("R9 set", pin_a, 1);
    wr_act(0, 2'b10); wr_cnt(40); one_tick(); chk("R9 clear", pin_a, 0);
    wr_act(0, 2'b11); wr_cnt(40); one_tick();
    wr_act(0, 2'b00); wr_cnt(40); one_tick(); chk("R9 none", pin_a, 1);
  endtask

  task automatic t_newact();
    wr_act(0, 2'b10); chk("R10 write no effect", pin_a, 1);
    cyc(); chk("R10 still waiting", pin_a, 1);
    wr_cnt(40); one_tick(); chk("R10 applies at match", pin_a, 0);
  endtask

  task automatic t_force();
    logic [15:0] c;
    flga_clr = 1; flgb_clr = 1; cyc();
    wr_act(0, 2'b01); wr_act(1, 2'b11);
    c = count;
    force_a = 1; cyc();
    chk("R11 force toggles", pin_a, 1); chk("R11 no flag", flag_a, 0);
    chk("R11 count kept", count, c);
    force_b = 1; cyc();
    chk("R11 force set b", pin_b, 1); chk("R11 no flag b", flag_b, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    t_reset(); t_normal(); t_ovf(); t_ctc_a(); t_ctc_cap(); t_hold();
    t_write(); t_flags(); t_pins(); t_newact(); t_force();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule